// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the serial front end of a 2048-byte nonvolatile memory. An SPI mode-0 master drives chip select, serial clock and serial data in, and reads serial data out. The block is clocked by a faster system clock. It treats SCK, CS and HOLD as synchronous inputs and finds SCK edges by comparing each sample with the previous one. Every frame opens with an 8-bit instruction. A read or write instruction then carries a 16-bit address, of which only the low 11 bits are kept. All fields travel most significant bit first.

The block owns the write-enable latch and the three nonvolatile status bits (protect-enable and two block-protect bits). For array reads it fetches bytes from a byte-wide array port that answers one clock after a fetch strobe. Incoming write bytes go to a separate page-write unit, which buffers them and later programs the array. That unit reports its program cycle back through a busy level and a done pulse.

A hold input freezes the serial state in the middle of a byte without ending the frame.

Top module: `spi_mem_slave`

## Requirements
- R1: Instruction, address and data bits are taken from `si` on rising SCK edges while `cs_n` is low, MSB first. The opcodes are 0x01 status write, 0x02 write, 0x03 read, 0x04 write disable, 0x05 status read and 0x06 write enable.
- R2: The write-enable latch (status bit 1) is set only when `cs_n` rises directly after the eighth bit of a 0x06 instruction. One or more further SCK rising edges in that frame cancel the set.
- R3: A 0x02 instruction given while the latch is clear is ignored until `cs_n` rises. This includes the case where 0x06 came earlier in the same frame. No `pw_valid` is produced.
- R4: After 0x02, the upper five bits of the 16-bit address are ignored. Each complete data byte produces one `pw_valid` pulse carrying its address and data. Successive addresses wrap inside the 16-byte page, so 0x00F is followed by 0x000.
- R5: `cs_n` rising on a byte boundary after at least one write data byte gives one `pw_commit` pulse. Rising inside a byte instead gives one `pw_abort` pulse.
- R6: 0x03 returns the array byte at the 11-bit address on `so`, MSB first. `so` changes after SCK falling edges. The address increments after every byte and rolls over from 0x7FF to 0x000.
- R7: 0x05 returns the status byte {WPEN, 0, 0, 0, BP1, BP0, WEL, WIP} (bit 7 down to bit 0), repeated for as long as SCK runs.
- R8: While `pw_busy` is high, 0x03 is refused: no `mem_rd` strobe and `so_en` stays low. 0x05 still works and shows WIP = 1.
- R9: A `pw_done` pulse clears the write-enable latch. So does a 0x04 instruction.
- R10: 0x01 with the latch set loads WPEN, BP1 and BP0 from data bits 7, 3 and 2 when `cs_n` rises on a byte boundary, and clears the latch. Without the latch it has no effect.
- R11: While `hold_n` is low in a frame, SCK edges are ignored and `so_en` is low. After release, the transfer continues with the next bit.
- R12: Outside a frame, and at the start of one, `so_en` is low. An unknown opcode makes the rest of its frame, including later opcodes, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock (mode 0) |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause the transfer, active low |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output drive enable for `so` |
| mem_rd | output | 1 | Array fetch strobe |
| mem_addr | output | 11 | Array fetch address |
| mem_rdata | input | 8 | Array byte, valid one clock after `mem_rd` |
| pw_valid | output | 1 | Write data byte strobe to the page-write unit |
| pw_addr | output | 11 | Address of the write byte |
| pw_data | output | 8 | Write byte |
| pw_commit | output | 1 | Start the program cycle |
| pw_abort | output | 1 | Discard the buffered bytes |
| pw_busy | input | 1 | Program cycle in progress |
| pw_done | input | 1 | Program cycle finished (one-clock pulse) |

## Verification
Each SCK edge is seen one system clock after the bench drives it. A write byte strobe appears one clock after the eighth rising edge. Status and commit effects appear one clock after `cs_n` rises. A read byte is in the output register three clocks after the last address bit. Each `so` bit changes one clock after a falling edge. The bench holds each SCK half period for four system clocks and samples `so` at the end of the low half, just before it raises SCK, so every result has settled by then. Strobes are counted by a monitor on the falling system clock edge. All latch and status effects are read back through a later status-read frame.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    PH_CMD, PH_AHI, PH_ALO, PH_RDDATA, PH_WRDATA, PH_STAT, PH_WRSTAT, PH_SKIP
  } phase_t;

  // status layout: bit7 protect-enable, bit3/bit2 block protect, bit1 latch, bit0 busy
  function automatic logic [7:0] pack_status(input logic wpen, input logic bp1,
                                             input logic bp0, input logic wel,
                                             input logic wip);
    return {wpen, 3'b000, bp1, bp0, wel, wip};
  endfunction

  // sequential read pointer: increments and rolls over at 2**aw
  function automatic logic [15:0] seq_next(input logic [15:0] a, input int unsigned aw);
    logic [15:0] m;
    m = 16'((32'd1 << aw) - 32'd1);
    return (a + 16'd1) & m;
  endfunction

  // write pointer: increments only the in-page bits
  function automatic logic [15:0] page_next(input logic [15:0] a, input int unsigned pw);
    logic [15:0] m;
    m = 16'((32'd1 << pw) - 32'd1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

endpackage

// File: rtl/spi_edge_sense.sv
module spi_edge_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  output logic rise_ev,
  output logic fall_ev,
  output logic end_ev
);
  logic sck_q;
  logic cs_q;
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign live    = !cs_n && hold_n;
  assign rise_ev = live && sck && !sck_q;
  assign fall_ev = live && !sck && sck_q;
  assign end_ev  = cs_n && !cs_q;
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       rise_ev,
  input  logic       si,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output logic [2:0] bit_cnt
);
  logic [6:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_cnt <= '0;
    end else if (clr) begin
      bit_cnt <= '0;
    end else if (rise_ev) begin
      sh      <= {sh[5:0], si};
      bit_cnt <= bit_cnt + 3'd1;
    end
  end

  assign byte_done = rise_ev && (bit_cnt == 3'd7);
  assign byte_val  = {sh, si};
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       fall_ev,
  input  logic       load,
  input  logic [7:0] load_val,
  output logic       so,
  output logic       byte_sent
);
  logic [7:0] out_sr;
  logic [2:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sr <= '0;
      cnt    <= '0;
      so     <= 1'b0;
    end else begin
      if (clr) begin
        cnt <= '0;
      end else if (fall_ev) begin
        so     <= out_sr[7];
        out_sr <= {out_sr[6:0], 1'b0};
        cnt    <= cnt + 3'd1;
      end
      if (load) out_sr <= load_val;
    end
  end

  assign byte_sent = fall_ev && (cnt == 3'd7);
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_en,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              pw_valid,
  output logic [ADDR_W-1:0] pw_addr,
  output logic [7:0]        pw_data,
  output logic              pw_commit,
  output logic              pw_abort,
  input  logic              pw_busy,
  input  logic              pw_done
);
  localparam int HI_W = ADDR_W - 8;

  // named internal events
  logic       rise_ev, fall_ev, frame_end;
  logic       byte_done, tx_fall, tx_sent, tx_load;
  logic [7:0] byte_val, tx_val, status_now;
  logic [2:0] rx_cnt;

  phase_t            phase;
  logic [ADDR_W-1:0] cur_addr;
  logic              is_write, wel, wpen, bp1, bp0;
  logic              wren_armed, wr_got, wrsr_got, load_pend;
  logic [2:0]        wrsr_bits;

  spi_edge_sense u_edge (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .end_ev(frame_end)
  );

  spi_rx_shift u_rx (
    .clk(clk), .rst_n(rst_n), .clr(cs_n), .rise_ev(rise_ev), .si(si),
    .byte_done(byte_done), .byte_val(byte_val), .bit_cnt(rx_cnt)
  );

  assign status_now = pack_status(wpen, bp1, bp0, wel, pw_busy);
  assign tx_fall    = fall_ev && (phase == PH_RDDATA || phase == PH_STAT);
  assign tx_load    = (byte_done && phase == PH_CMD && byte_val == OP_RDSR)
                    || (tx_sent && phase == PH_STAT)
                    || (load_pend && phase == PH_RDDATA);
  assign tx_val     = load_pend ? mem_rdata : status_now;

  spi_tx_shift u_tx (
    .clk(clk), .rst_n(rst_n), .clr(cs_n), .fall_ev(tx_fall),
    .load(tx_load), .load_val(tx_val), .so(so), .byte_sent(tx_sent)
  );

  assign so_en = !cs_n && hold_n && (phase == PH_RDDATA || phase == PH_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_CMD;
      cur_addr   <= '0;
      is_write   <= 1'b0;
      wel        <= 1'b0;
      wpen       <= 1'b0;
      bp1        <= 1'b0;
      bp0        <= 1'b0;
      wren_armed <= 1'b0;
      wr_got     <= 1'b0;
      wrsr_got   <= 1'b0;
      wrsr_bits  <= '0;
      load_pend  <= 1'b0;
      mem_rd     <= 1'b0;
      mem_addr   <= '0;
      pw_valid   <= 1'b0;
      pw_addr    <= '0;
      pw_data    <= '0;
      pw_commit  <= 1'b0;
      pw_abort   <= 1'b0;
    end else begin
      mem_rd    <= 1'b0;
      pw_valid  <= 1'b0;
      pw_commit <= 1'b0;
      pw_abort  <= 1'b0;
      load_pend <= mem_rd;

      if (pw_done) wel <= 1'b0;

      if (frame_end) begin
        if (wren_armed) wel <= 1'b1;
        if (phase == PH_WRDATA && wr_got) begin
          if (rx_cnt == 3'd0) pw_commit <= 1'b1;
          else                pw_abort  <= 1'b1;
        end
        if (phase == PH_WRSTAT && wrsr_got && rx_cnt == 3'd0) begin
          wpen <= wrsr_bits[2];
          bp1  <= wrsr_bits[1];
          bp0  <= wrsr_bits[0];
          wel  <= 1'b0;
        end
        wren_armed <= 1'b0;
        wr_got     <= 1'b0;
        wrsr_got   <= 1'b0;
      end

      if (cs_n) begin
        phase <= PH_CMD;
      end else begin
        if (rise_ev) wren_armed <= 1'b0;
        if (byte_done) begin
          unique case (phase)
            PH_CMD: begin
              phase <= PH_SKIP;
              if (byte_val == OP_WREN) begin
                wren_armed <= 1'b1;
              end else if (byte_val == OP_WRDI) begin
                wel <= 1'b0;
              end else if (byte_val == OP_RDSR) begin
                phase <= PH_STAT;
              end else if (byte_val == OP_READ && !pw_busy) begin
                is_write <= 1'b0;
                phase    <= PH_AHI;
              end else if (byte_val == OP_WRITE && wel && !pw_busy) begin
                is_write <= 1'b1;
                phase    <= PH_AHI;
              end else if (byte_val == OP_WRSR && wel && !pw_busy) begin
                phase <= PH_WRSTAT;
              end
            end
            PH_AHI: begin
              cur_addr[ADDR_W-1:8] <= byte_val[HI_W-1:0];
              phase <= PH_ALO;
            end
            PH_ALO: begin
              cur_addr[7:0] <= byte_val;
              if (is_write) begin
                phase <= PH_WRDATA;
              end else begin
                phase    <= PH_RDDATA;
                mem_rd   <= 1'b1;
                mem_addr <= {cur_addr[ADDR_W-1:8], byte_val};
              end
            end
            PH_WRDATA: begin
              pw_valid <= 1'b1;
              pw_addr  <= cur_addr;
              pw_data  <= byte_val;
              cur_addr <= ADDR_W'(page_next(16'(cur_addr), PAGE_W));
              wr_got   <= 1'b1;
            end
            PH_WRSTAT: begin
              wrsr_bits <= {byte_val[7], byte_val[3], byte_val[2]};
              wrsr_got  <= 1'b1;
            end
            default: ;
          endcase
        end
        if (tx_sent && phase == PH_RDDATA) begin
          cur_addr <= ADDR_W'(seq_next(16'(cur_addr), ADDR_W));
          mem_addr <= ADDR_W'(seq_next(16'(cur_addr), ADDR_W));
          mem_rd   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_mem_slave_props.sv
module spi_mem_slave_props (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       hold_n,
  input logic       so_en,
  input logic       mem_rd,
  input logic       pw_valid,
  input logic       pw_commit,
  input logic       pw_abort,
  input logic       pw_busy,
  input logic       pw_done,
  input logic       wel,
  input logic       frame_end,
  input logic [2:0] bit_cnt
);
  assert_frame_start_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !so_en);

  assert_latch_set_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(frame_end));

  assert_write_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid |-> wel);

  assert_done_clears_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_done && !frame_end) |=> !wel);

  assert_hold_freezes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !cs_n) |=> $stable(bit_cnt));

  assert_close_outside_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_commit || pw_abort) |-> (cs_n && !(pw_commit && pw_abort)));

  assert_no_fetch_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !pw_busy);
endmodule

bind spi_mem_slave spi_mem_slave_props u_props (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so_en(so_en),
  .mem_rd(mem_rd), .pw_valid(pw_valid), .pw_commit(pw_commit),
  .pw_abort(pw_abort), .pw_busy(pw_busy), .pw_done(pw_done), .wel(wel),
  .frame_end(frame_end), .bit_cnt(rx_cnt)
);

// File: tb/spi_mem_slave_test.sv
module spi_mem_slave_test;
  localparam int HP = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic pw_busy = 1'b0, pw_done = 1'b0;
  logic [7:0] mem_rdata = 8'h00;
  logic so, so_en, mem_rd, pw_valid, pw_commit, pw_abort;
  logic [10:0] mem_addr, pw_addr;
  logic [7:0] pw_data;

  int total = 0, bad = 0;
  int cap_n = 0, n_commit = 0, n_abort = 0, n_memrd = 0, so_seen = 0;
  logic [10:0] cap_a [0:31];
  logic [7:0]  cap_d [0:31];

  spi_mem_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_en(so_en), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pw_valid(pw_valid), .pw_addr(pw_addr), .pw_data(pw_data), .pw_commit(pw_commit),
    .pw_abort(pw_abort), .pw_busy(pw_busy), .pw_done(pw_done)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] memval(input logic [10:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd37 + 16'(a >> 3);
    return t[7:0] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memval(mem_addr);

  always @(negedge clk) begin
    if (pw_valid) begin
      if (cap_n < 32) begin cap_a[cap_n] = pw_addr; cap_d[cap_n] = pw_data; end
      cap_n++;
    end
    if (pw_commit) n_commit++;
    if (pw_abort) n_abort++;
    if (mem_rd) n_memrd++;
    if (so_en) so_seen++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fbegin();
    cs_n = 1'b0; clks(2);
  endtask

  task automatic fend();
    clks(2); cs_n = 1'b1; clks(6);
  endtask

  task automatic xbit(input logic b, output logic r);
    si = b; clks(HP); r = so; sck = 1'b1; clks(HP); sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
  endtask

  task automatic one_cmd(input logic [7:0] op);
    logic [7:0] d;
    fbegin(); xbyte(op, d); fend();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] d;
    fbegin(); xbyte(8'h05, d); xbyte(8'h00, s); fend();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] s, d, r;
    logic b;
    int base, nbad;
    clks(4); rst_n = 1'b1; clks(2);

    // R12 reset state
    chk("R12 so_en after reset", so_en, 0);
    chk("R12 strobes after reset", {mem_rd, pw_valid, pw_commit, pw_abort}, 0);

    // R7 status repeats, initial zero
    fbegin(); xbyte(8'h05, d); xbyte(8'h00, s); xbyte(8'h00, r); fend();
    chk("R7 first status", s, 8'h00);
    chk("R7 repeated status", r, 8'h00);

    // R2 extra bit after enable cancels
    fbegin(); xbyte(8'h06, d); xbit(1'b0, b); fend();
    rd_status(s);
    chk("R2 extra bit no latch", s, 8'h00);

    // R3 enable and write in one frame
    fbegin(); xbyte(8'h06, d); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h10, d); xbyte(8'hAA, d); fend();
    chk("R3 no write bytes", cap_n, 0);
    rd_status(s);
    chk("R3 latch still clear", s, 8'h00);

    // R12 unknown opcode swallows later enable
    so_seen = 0;
    fbegin(); xbyte(8'hA5, d); xbyte(8'h06, d); xbyte(8'h05, d); xbyte(8'h00, d); fend();
    chk("R12 so_en in unknown frame", so_seen, 0);
    rd_status(s);
    chk("R12 unknown no latch", s, 8'h00);

    // R2 R7 proper enable, repeated status
    one_cmd(8'h06);
    fbegin(); xbyte(8'h05, d);
    for (int k = 0; k < 3; k++) begin xbyte(8'h00, s); chk("R7 R2 latch status repeat", s, 8'h02); end
    fend();

    // R9 disable instruction
    one_cmd(8'h04);
    rd_status(s);
    chk("R9 disable clears", s, 8'h00);

    // R4 R5 page write with wrap, upper address bits ignored, R1 MSB first
    one_cmd(8'h06);
    fbegin(); xbyte(8'h02, d); xbyte(8'hF8, d); xbyte(8'h0D, d);
    for (int k = 0; k < 5; k++) xbyte(8'hC0 + 8'(k), d);
    fend();
    chk("R4 byte count", cap_n, 5);
    for (int k = 0; k < 5; k++) begin
      chk("R4 write address", cap_a[k], {7'h00, 4'(13 + k)});
      chk("R1 write data", cap_d[k], 8'hC0 + 8'(k));
    end
    chk("R5 commit", n_commit, 1);
    chk("R5 no abort", n_abort, 0);

    // R8 busy: status works, read refused
    pw_busy = 1'b1; clks(2);
    rd_status(s);
    chk("R8 status while busy", s, 8'h03);
    so_seen = 0; n_memrd = 0;
    fbegin(); xbyte(8'h03, d); xbyte(8'h00, d); xbyte(8'h40, d); xbyte(8'h00, d); fend();
    chk("R8 so_en refused read", so_seen, 0);
    chk("R8 no fetch", n_memrd, 0);
    pw_busy = 1'b0; clks(2);
    pw_done = 1'b1; clks(1); pw_done = 1'b0; clks(2);
    rd_status(s);
    chk("R9 done clears latch", s, 8'h00);

    // R5 abort on partial byte
    one_cmd(8'h06);
    fbegin(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h20, d);
    xbyte(8'h11, d); xbyte(8'h22, d); xbit(1'b1, b); xbit(1'b0, b); xbit(1'b1, b); fend();
    chk("R5 abort count", n_abort, 1);
    chk("R5 commit unchanged", n_commit, 1);
    one_cmd(8'h04);

    // R10 status write
    fbegin(); xbyte(8'h01, d); xbyte(8'h8C, d); fend();
    rd_status(s);
    chk("R10 no latch no effect", s, 8'h00);
    one_cmd(8'h06);
    fbegin(); xbyte(8'h01, d); xbyte(8'hFF, d); fend();
    rd_status(s);
    chk("R10 bits loaded latch cleared", s, 8'h8C);
    one_cmd(8'h06);
    fbegin(); xbyte(8'h01, d); xbyte(8'h00, d); fend();
    rd_status(s);
    chk("R10 bits cleared", s, 8'h00);

    // R6 sequential read with rollover
    fbegin(); xbyte(8'h03, d); xbyte(8'hA7, d); xbyte(8'hF0, d);
    nbad = 0;
    for (int k = 0; k < 64; k++) begin
      xbyte(8'h00, r);
      if (r !== memval(11'((16'h7F0 + 16'(k)) & 16'h7FF))) nbad++;
    end
    fend();
    chk("R6 rollover read mismatches", nbad, 0);

    // R6 sweep of start addresses
    for (int s0 = 0; s0 < 16; s0++) begin
      base = (s0 * 16'h0123) & 16'h7FF;
      fbegin(); xbyte(8'h03, d); xbyte(8'(base >> 8), d); xbyte(8'(base), d);
      nbad = 0;
      for (int k = 0; k < 4; k++) begin
        xbyte(8'h00, r);
        if (r !== memval(11'((base + k) & 16'h7FF))) nbad++;
      end
      fend();
      chk("R6 sweep read", nbad, 0);
    end

    // R11 hold mid-byte
    fbegin(); xbyte(8'h03, d); xbyte(8'h01, d); xbyte(8'h23, d);
    xbyte(8'h00, r);
    chk("R11 byte before hold", r, memval(11'h123));
    for (int i = 7; i >= 5; i--) xbit(1'b0, r[i]);
    clks(2); hold_n = 1'b0; clks(2);
    chk("R11 so_en during hold", so_en, 0);
    for (int t = 0; t < 3; t++) begin sck = 1'b1; clks(HP); sck = 1'b0; clks(HP); end
    hold_n = 1'b1; clks(2);
    for (int i = 4; i >= 0; i--) xbit(1'b0, r[i]);
    fend();
    chk("R11 byte across hold", r, memval(11'h124));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule